// File: doc/BRIEF.md
# Dual-Polarity Edge Event Register

This block watches one port of sixteen already-filtered digital inputs and records, per channel, whether a rising or a falling transition has been seen. It samples the inputs on the system clock (16 MHz in the intended system), qualifies each transition with a per-channel rise-enable and fall-enable bit, and sets the matching bit in one of two sticky event registers. One register holds rising events and the other holds falling events, so a channel enabled for both polarities can record both.

A single port-level service marker tells the surrounding control logic that there is something to collect. Software, through a simple read strobe and a one-bit register select, fetches one event register at a time. The fetch returns the contents and clears that register. Each fetch holds the marker low for two clocks. After that, the marker comes back if the other register, or a newly recorded event, still needs service. Transitions that land in the same clock as a fetch are held in a one-deep queue and merged into the cleared register on the next clock, so no transition is lost.

Top module: `edge_event_port`

## Requirements
- R1: A 0-to-1 change of `din[i]` with `rise_en[i]` high sets bit i of the rising event register at the clock edge that first samples the new level. The set bit stays set until that register is read.
- R2: A 1-to-0 change of `din[i]` with `fall_en[i]` high sets bit i of the falling event register at the clock edge that first samples the new level. The set bit stays set until that register is read.
- R3: A channel with both enables high records its rising and its falling transitions independently, each in its own register.
- R4: A channel whose enable bit for a polarity is low never sets that polarity's event bit, however its input toggles.
- R5: After reset, `marker` and `rd_data` are zero. Outside blanking, `marker` is high exactly when some event bit, recorded or queued, is set for a channel whose enable of that polarity is high.
- R6: A clock with `rd_stb` high selects a register with `rd_sel`: 0 selects rising and 1 selects falling. The selected contents, including queued bits, appear on `rd_data` after that edge and are held there until the next strobe. The selected register is cleared.
- R7: Every read strobe forces `marker` low for the two clocks that follow the strobe edge.
- R8: After the two-clock blanking, `marker` rises again if the register that was not read holds an enabled bit.
- R9: Transitions sampled in the same clock as a read of their register are queued and ORed into it one clock later. A second read in the next clock returns them, so none is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | NCH | Filtered channel inputs |
| rise_en | input | NCH | Per-channel rising-edge enable |
| fall_en | input | NCH | Per-channel falling-edge enable |
| rd_stb | input | 1 | Read strobe, one clock per read |
| rd_sel | input | 1 | Register select: 0 rising, 1 falling |
| rd_data | output | NCH | Contents returned by the last read |
| marker | output | 1 | Port service marker |

## Verification
The collision that matters is a read and a new transition landing in the same clock. The bench provokes this in three ways. In the first, an edge comes on the register being read. In the second, the strobe is held for two clocks so that the queued bits are read before they merge. In the third, an edge of the other polarity arrives during the read. In each case the bench judges the result from the value the read returns and from the marker after blanking. Both are compared against masks computed from the driven pattern and the enables.

// File: rtl/edge_event_pkg.sv
package edge_event_pkg;
  typedef enum logic {
    SEL_RISE = 1'b0,
    SEL_FALL = 1'b1
  } evt_sel_e;

  localparam int unsigned NUM_POL = 2;
endpackage

// File: rtl/edge_sampler.sv
module edge_sampler #(
  parameter int unsigned NCH = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] din,
  input  logic [NCH-1:0] rise_en,
  input  logic [NCH-1:0] fall_en,
  output logic [NCH-1:0] rise_hit,
  output logic [NCH-1:0] fall_hit
);
  logic [NCH-1:0] prev_q, prev_d;

  assign prev_d = din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign rise_hit[c] = rise_en[c] &  din[c] & ~prev_q[c];
    assign fall_hit[c] = fall_en[c] & ~din[c] &  prev_q[c];
  end
endmodule

// File: rtl/event_bank.sv
module event_bank #(
  parameter int unsigned NCH = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] hit,
  input  logic           rd_clr,
  output logic [NCH-1:0] view
);
  logic [NCH-1:0] evt_q, evt_d;
  logic [NCH-1:0] pend_q, pend_d;

  always_comb begin
    if (rd_clr) begin
      evt_d  = '0;
      pend_d = hit;
    end else begin
      evt_d  = evt_q | pend_q | hit;
      pend_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q  <= '0;
      pend_q <= '0;
    end else begin
      evt_q  <= evt_d;
      pend_q <= pend_d;
    end
  end

  assign view = evt_q | pend_q;
endmodule

// File: rtl/marker_ctrl.sv
module marker_ctrl #(
  parameter int unsigned BLANK = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_stb,
  input  logic any_hit,
  output logic marker
);
  localparam int unsigned CW = $clog2(BLANK + 1);
  localparam logic [CW-1:0] BLANK_LD = CW'(BLANK);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (rd_stb)            cnt_d = BLANK_LD;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    else                   cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign marker = (cnt_q == '0) & any_hit;
endmodule

// File: rtl/edge_event_port.sv
module edge_event_port
  import edge_event_pkg::*;
#(
  parameter int unsigned NCH   = 16,
  parameter int unsigned BLANK = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] din,
  input  logic [NCH-1:0] rise_en,
  input  logic [NCH-1:0] fall_en,
  input  logic           rd_stb,
  input  logic           rd_sel,
  output logic [NCH-1:0] rd_data,
  output logic           marker
);
  evt_sel_e                    sel_e;
  logic [NUM_POL-1:0][NCH-1:0] hit_vec;
  logic [NUM_POL-1:0][NCH-1:0] view_vec;
  logic [NUM_POL-1:0]          clr_vec;
  logic [NCH-1:0]              rd_q, rd_d;
  logic                        any_hit;

  assign sel_e = evt_sel_e'(rd_sel);

  edge_sampler #(.NCH(NCH)) u_samp (
    .clk      (clk),
    .rst_n    (rst_n),
    .din      (din),
    .rise_en  (rise_en),
    .fall_en  (fall_en),
    .rise_hit (hit_vec[SEL_RISE]),
    .fall_hit (hit_vec[SEL_FALL])
  );

  for (genvar p = 0; p < NUM_POL; p++) begin : g_bank
    assign clr_vec[p] = rd_stb & (sel_e == evt_sel_e'(p));
    event_bank #(.NCH(NCH)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .hit    (hit_vec[p]),
      .rd_clr (clr_vec[p]),
      .view   (view_vec[p])
    );
  end

  always_comb begin
    if (rd_stb) rd_d = view_vec[sel_e];
    else        rd_d = rd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_d;
  end

  assign rd_data = rd_q;
  assign any_hit = |((view_vec[SEL_RISE] & rise_en) | (view_vec[SEL_FALL] & fall_en));

  marker_ctrl #(.BLANK(BLANK)) u_mark (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_stb  (rd_stb),
    .any_hit (any_hit),
    .marker  (marker)
  );
endmodule

// File: rtl/edge_event_port_chk.sv
module edge_event_port_chk #(
  parameter int unsigned NCH = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NCH-1:0]       rise_en,
  input logic [NCH-1:0]       fall_en,
  input logic                 rd_stb,
  input logic                 rd_sel,
  input logic [NCH-1:0]       rd_data,
  input logic                 marker,
  input logic [1:0][NCH-1:0]  view_vec
);
  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R7
  blank_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> !marker);

  // R7
  blank_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> ##1 !marker);

  // R6
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !rd_stb) |=> $stable(rd_data));

  // R6
  rd_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !rd_sel) |=> (rd_data == $past(view_vec[0])));

  // R4
  rise_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ((view_vec[0] & ~$past(view_vec[0]) & ~$past(rise_en)) == '0));

  // R4
  fall_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ((view_vec[1] & ~$past(view_vec[1]) & ~$past(fall_en)) == '0));
endmodule

bind edge_event_port edge_event_port_chk #(.NCH(NCH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rise_en  (rise_en),
  .fall_en  (fall_en),
  .rd_stb   (rd_stb),
  .rd_sel   (rd_sel),
  .rd_data  (rd_data),
  .marker   (marker),
  .view_vec (view_vec)
);

// File: tb/edge_event_port_bench.sv
module edge_event_port_bench;
  localparam int NCH = 16;
  localparam time CLK_PERIOD = 62ns;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [NCH-1:0] din, rise_en, fall_en, rd_data;
  logic           rd_stb, rd_sel, marker;
  int             total = 0;
  int             bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_event_port u_edge_event_port (
    .clk(clk), .rst_n(rst_n), .din(din), .rise_en(rise_en), .fall_en(fall_en),
    .rd_stb(rd_stb), .rd_sel(rd_sel), .rd_data(rd_data), .marker(marker)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic do_read(input logic sel, input logic [NCH-1:0] exp, input logic exp_mark,
                         input string req);
    rd_stb = 1'b1;
    rd_sel = sel;
    cyc();
    rd_stb = 1'b0;
    chk({req, " R6 read value"}, 32'(rd_data), 32'(exp));
    chk("R7 blank 1", 32'(marker), 0);
    cyc();
    chk("R7 blank 2", 32'(marker), 0);
    cyc();
    chk("R8 marker after blank", 32'(marker), 32'(exp_mark));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [NCH-1:0] pats [4];
    pats[0] = 16'h1234; pats[1] = 16'hFFFF; pats[2] = 16'h8001; pats[3] = 16'h5AA5;
    rst_n = 1'b0; din = '0; rise_en = '0; fall_en = '0; rd_stb = 1'b0; rd_sel = 1'b0;
    cyc(); cyc();
    rst_n = 1'b1;
    cyc();
    chk("R5 reset marker", 32'(marker), 0);
    chk("R5 reset rd_data", 32'(rd_data), 0);

    // R1 R2 R3 R4: every channel, every enable combination
    for (int ch = 0; ch < NCH; ch++) begin
      for (int mode = 0; mode < 4; mode++) begin
        logic [NCH-1:0] bit_m;
        bit_m   = NCH'(1) << ch;
        rise_en = mode[0] ? bit_m : '0;
        fall_en = mode[1] ? bit_m : '0;
        din = bit_m;  cyc();
        chk("R1 R4 marker after rise", 32'(marker), 32'(mode[0]));
        din = '0;     cyc();
        chk("R3 R5 marker after toggle", 32'(marker), 32'(mode != 0));
        do_read(1'b0, mode[0] ? bit_m : '0, mode[1], "R1 R4");
        do_read(1'b1, mode[1] ? bit_m : '0, 1'b0, "R2 R3");
      end
    end

    // R3: multi-channel patterns with mixed masks
    rise_en = 16'hA5C3;
    fall_en = 16'h3C5A;
    for (int k = 0; k < 4; k++) begin
      din = pats[k]; cyc();
      din = '0;      cyc();
      chk("R5 pattern marker", 32'(marker), 32'((pats[k] & (rise_en | fall_en)) != 0));
      do_read(1'b0, pats[k] & rise_en, (pats[k] & fall_en) != 0, "R3 rise");
      do_read(1'b1, pats[k] & fall_en, 1'b0, "R3 fall");
    end

    // R9: edge in the same clock as a read of its register
    rise_en = '1; fall_en = '0; din = '0; cyc();
    rd_stb = 1'b1; rd_sel = 1'b0; din = 16'h00F0;
    cyc();
    rd_stb = 1'b0;
    chk("R9 read excludes same-cycle edge", 32'(rd_data), 0);
    cyc(); cyc();
    chk("R9 queued edge raises marker", 32'(marker), 1);
    do_read(1'b0, 16'h00F0, 1'b0, "R9 merged");

    // R9: back-to-back reads collect the queue
    din = '0; cyc();
    rd_stb = 1'b1; rd_sel = 1'b0; din = 16'h0F00;
    cyc();
    cyc();
    rd_stb = 1'b0;
    chk("R9 back-to-back read", 32'(rd_data), 32'h0F00);
    cyc(); cyc();
    chk("R9 empty after second read", 32'(marker), 0);

    // R8: falling edge while the rising register is read
    fall_en = '1;
    rd_stb = 1'b1; rd_sel = 1'b0; din = '0;
    cyc();
    rd_stb = 1'b0;
    chk("R8 rise empty", 32'(rd_data), 0);
    cyc();
    chk("R7 blank during fall event", 32'(marker), 0);
    cyc();
    chk("R8 fall event reasserts marker", 32'(marker), 1);
    do_read(1'b1, 16'h0F00, 1'b0, "R8 fall");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule